// File: doc/BRIEF.md
# Power-of-Two Input Debounce Filter

This block sits on one pad's input path, after the synchronizer and before the event detector. It hides level changes on the raw input that do not last long enough. The required hold time is a power of two of a base period. The base period arrives as a one-cycle strobe, `tick_stb`, from a divider outside this block.

The 5-bit configuration word `dbc_cfg` holds two fields. Bit 0 turns debouncing on. Bits 4:1 hold the exponent v, and the hold time is 2^v strobes. Only exponents 3 to 15 are legal; with 31.25 µs strobes that covers roughly 250 µs to 1.024 s. A separate input, `glitch_sel`, must be set and cleared together with the enable bit. The filter engages only when the enable bit is set, `glitch_sel` is set and the exponent is legal. In every other state the raw level goes straight to the output.

Top module: `pad_debounce_filter`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `pad_filt` equals `pad_raw`.
- R2: With `dbc_cfg[0]` clear, `pad_filt` equals `pad_raw` combinationally, whatever `tick_stb` does.
- R3: With the exponent `dbc_cfg[4:1]` equal to 0, 1 or 2, the filter stays off and `pad_filt` equals `pad_raw`, even with enable and `glitch_sel` set.
- R4: With `glitch_sel` clear, the filter stays off and `pad_filt` equals `pad_raw`.
- R5: In the cycle the filter becomes engaged, `pad_filt` equals the current `pad_raw`, so engaging produces no edge.
- R6: Once engaged, a new raw level reaches `pad_filt` in the cycle after the 2^v-th `tick_stb` pulse during which the raw level differed from `pad_filt` the whole time.
- R7: A raw return to the filtered level before 2^v strobes restarts the count from zero, and `pad_filt` does not change.
- R8: Without `tick_stb` pulses, an engaged filter never changes `pad_filt`, however long the raw level differs.
- R9: The largest exponent, 15, delays a change by exactly 32768 strobes.
- R10: The filter treats rising and falling changes the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_raw | input | 1 | Synchronized raw pad level |
| tick_stb | input | 1 | One-cycle base-period strobe |
| glitch_sel | input | 1 | Glitch-filter select; engages together with the enable |
| dbc_cfg | input | 5 | Bit 0 debounce enable, bits 4:1 exponent v |
| pad_filt | output | 1 | Filtered pad level |

## Verification
The passthrough results (R1 to R4) and the engage result (R5) are combinational. They are due in the same cycle the inputs change, and the bench checks them one time unit after driving. A debounced change (R6, R7, R9, R10) is due one cycle after the clock edge that samples the 2^v-th strobe. The bench drives inputs on the falling edge, compares a strobe-counting reference model on every falling edge, and also checks the exact cycle before and after each expected flip. With no strobes (R8), the output must stay constant for the whole window, and the per-cycle comparison covers every cycle of it.

// File: rtl/pad_dbc_pkg.sv
package pad_dbc_pkg;
  localparam int unsigned EXP_W   = 4;
  localparam int unsigned CFG_W   = EXP_W + 1;
  localparam int unsigned EXP_MIN = 3;
  localparam int unsigned EXP_MAX = 15;

  typedef struct packed {
    logic [EXP_W-1:0] expo;
    logic             en;
  } dbc_cfg_t;

  function automatic logic exp_legal(input logic [EXP_W-1:0] e);
    return (int'(e) >= EXP_MIN) && (int'(e) <= EXP_MAX);
  endfunction
endpackage

// File: rtl/pad_dbc_decode.sv
module pad_dbc_decode
  import pad_dbc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic [CFG_W-1:0] cfg,
  input  logic             gsel,
  output logic             engage,
  output logic [CNT_W-1:0] limit
);
  dbc_cfg_t fields;

  always_comb begin
    fields = dbc_cfg_t'(cfg);
    engage = fields.en && gsel && exp_legal(fields.expo);
    limit  = (CNT_W'(1) << fields.expo) - CNT_W'(1);
  end
endmodule

// File: rtl/pad_dbc_counter.sv
module pad_dbc_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    done  = !clr && tick && (cnt_q == limit);
    cnt_d = cnt_q;
    if (clr || done)
      cnt_d = '0;
    else if (tick)
      cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  // R7
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/pad_debounce_filter.sv
module pad_debounce_filter
  import pad_dbc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pad_raw,
  input  logic             tick_stb,
  input  logic             glitch_sel,
  input  logic [CFG_W-1:0] dbc_cfg,
  output logic             pad_filt
);
  logic             engage;
  logic [CNT_W-1:0] limit;
  logic             act_q;
  logic             lvl_q, lvl_d;
  logic             steady;
  logic             differ;
  logic             cnt_clr;
  logic             hit;

  pad_dbc_decode #(.CNT_W(CNT_W)) u_decode (
    .cfg    (dbc_cfg),
    .gsel   (glitch_sel),
    .engage (engage),
    .limit  (limit)
  );

  pad_dbc_counter #(.CNT_W(CNT_W)) u_counter (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .tick  (tick_stb),
    .limit (limit),
    .done  (hit)
  );

  always_comb begin
    steady  = engage && act_q;
    differ  = pad_raw != lvl_q;
    cnt_clr = !steady || !differ;
    lvl_d   = lvl_q;
    if (!steady || hit)
      lvl_d = pad_raw;
    pad_filt = steady ? lvl_q : pad_raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      lvl_q <= 1'b0;
    end else begin
      act_q <= engage;
      lvl_q <= lvl_d;
    end
  end

  // R2
  passthru_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dbc_cfg[0] |-> (pad_filt == pad_raw));

  // R5
  engage_no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(engage) |-> (pad_filt == pad_raw));

  // R8
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (steady && $past(steady) && !$past(tick_stb)) |-> $stable(pad_filt));

  // R6
  change_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (steady && $past(steady) && (pad_filt != $past(pad_filt))) |-> $past(tick_stb));
endmodule

// File: tb/pad_debounce_filter_tb.sv
module pad_debounce_filter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pad_raw = 1'b0;
  logic       tick_stb = 1'b0;
  logic       glitch_sel = 1'b0;
  logic [4:0] dbc_cfg = 5'd0;
  logic       pad_filt;

  int    total = 0;
  int    bad = 0;
  int    tick_mode = 0;
  int    phase = 0;
  string req = "R1";

  int m_out = 0;
  int m_prev = 0;
  int m_run = 0;

  always #10 clk = ~clk;

  pad_debounce_filter u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .pad_raw    (pad_raw),
    .tick_stb   (tick_stb),
    .glitch_sel (glitch_sel),
    .dbc_cfg    (dbc_cfg),
    .pad_filt   (pad_filt)
  );

  function automatic int model_on();
    int e;
    e = int'(dbc_cfg[4:1]);
    return (dbc_cfg[0] && glitch_sel && e >= 3 && e <= 15) ? 1 : 0;
  endfunction

  function automatic int model_expect();
    return (model_on() != 0 && m_prev != 0) ? m_out : int'(pad_raw);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_out = 0; m_prev = 0; m_run = 0;
    end else begin
      if (model_on() != 0 && m_prev != 0) begin
        if (int'(pad_raw) != m_out) begin
          if (tick_stb) begin
            m_run = m_run + 1;
            if (m_run == (1 << int'(dbc_cfg[4:1]))) begin
              m_out = int'(pad_raw);
              m_run = 0;
            end
          end
        end else begin
          m_run = 0;
        end
      end else begin
        m_out = int'(pad_raw);
        m_run = 0;
      end
      m_prev = model_on();
    end
  end

  task automatic check(input string tag, input int act, input int exp_v);
    total++;
    if (act != exp_v) begin
      bad++;
      $display("FAIL %s: pad_filt=%0d expected=%0d at %0t", tag, act, exp_v, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(req, int'(pad_filt), model_expect());
      phase++;
      case (tick_mode)
        1:       tick_stb = 1'b1;
        2:       tick_stb = phase[0];
        default: tick_stb = 1'b0;
      endcase
    end
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog: run did not complete");
    finish_up();
  end

  initial begin
    // R1: reset with the filter configured, output follows raw
    dbc_cfg = {4'd3, 1'b1}; glitch_sel = 1'b1; pad_raw = 1'b1;
    #35;
    check("R1", int'(pad_filt), 1);
    @(negedge clk); rst_n = 1'b1; #1;
    check("R1", int'(pad_filt), 1);
    step(1);

    // R2: enable clear, passthrough while strobing
    req = "R2"; tick_mode = 1;
    dbc_cfg = {4'd3, 1'b0};
    for (int k = 0; k < 6; k++) begin
      pad_raw = k[0]; #1;
      check("R2", int'(pad_filt), k % 2);
      step(1);
    end

    // R5: engage with raw high, no edge
    req = "R5";
    pad_raw = 1'b1; dbc_cfg = {4'd3, 1'b1}; #1;
    check("R5", int'(pad_filt), 1);
    step(2);

    // R6 / R10: falling then rising, exponent 3, strobe every cycle
    req = "R6"; pad_raw = 1'b0;
    step(7); check("R6", int'(pad_filt), 1);
    step(1); check("R6", int'(pad_filt), 0);
    req = "R10"; pad_raw = 1'b1;
    step(7); check("R10", int'(pad_filt), 0);
    step(1); check("R10", int'(pad_filt), 1);

    // R7: bounce back restarts count
    req = "R7"; pad_raw = 1'b0;
    step(5); pad_raw = 1'b1; step(1); pad_raw = 1'b0;
    step(7); check("R7", int'(pad_filt), 1);
    step(1); check("R7", int'(pad_filt), 0);

    // R8: no strobes, no change
    req = "R8"; tick_mode = 0; pad_raw = 1'b1;
    step(60); check("R8", int'(pad_filt), 0);

    // R6 with exponent 4 and strobe on alternate cycles
    req = "R6"; tick_mode = 2; dbc_cfg = {4'd4, 1'b1};
    step(40); check("R6", int'(pad_filt), 1);

    // R3: illegal exponents give passthrough
    req = "R3"; tick_mode = 1;
    for (int e = 0; e < 3; e++) begin
      dbc_cfg = {e[3:0], 1'b1};
      pad_raw = 1'b0; #1; check("R3", int'(pad_filt), 0);
      step(1);
      pad_raw = 1'b1; #1; check("R3", int'(pad_filt), 1);
      step(1);
    end

    // R4: glitch select clear gives passthrough
    req = "R4"; dbc_cfg = {4'd3, 1'b1}; glitch_sel = 1'b0;
    pad_raw = 1'b0; #1; check("R4", int'(pad_filt), 0);
    step(1);
    pad_raw = 1'b1; #1; check("R4", int'(pad_filt), 1);
    step(1);

    // R9: largest exponent
    req = "R9"; glitch_sel = 1'b1; dbc_cfg = {4'd15, 1'b1}; #1;
    check("R5", int'(pad_filt), 1);
    step(2);
    pad_raw = 1'b0;
    step(32767); check("R9", int'(pad_filt), 1);
    step(1);     check("R9", int'(pad_filt), 0);

    step(3);
    finish_up();
  end
endmodule